// File: doc/BRIEF.md
# Decode-Stage Branch Redirect Unit

This block watches a group of decoded instructions belonging to one hardware thread. For every branch whose target is already resolved in decode, it compares that resolved target with the address fetch guessed for the instruction. The lowest-numbered lane that disagrees is the redirect point. One clock later the unit sends that thread a squash message toward fetch. The message carries the corrected next-PC pair, a taken indication, the offending sequence number and its micro-PC. When the thread was stalled, the unit also sends an unblock.

In the same cycle the unit produces corrected prediction fields for the offending instruction. It raises a block request when younger valid lanes remain behind the redirect point, so that the skid buffer keeps them. A running count of detected mispredictions is kept. A parameter fixes whether the target machine has a branch delay slot, and this choice changes how the redirect PC pair and the taken flag are formed. All address arithmetic wraps at the address width.

Top module: `dec_redirect`

## Requirements
- R1: A lane mispredicts when it is valid, its branch-known bit is set and its resolved target differs from its predicted PC. A group with no such lane produces no redirect.
- R2: On a redirect, the thread named by the group id sees its mispredict, prediction-bad and squash flags all high for exactly the following cycle. Every other thread sees none of them. All message fields of a thread are zero in cycles without a redirect for it.
- R3: The redirect message carries the offending lane's sequence number as the completed sequence number and its micro-PC as the next micro-PC.
- R4: With no delay slot, the redirect next PC is the target and the next-next PC is the target plus the instruction size. With a delay slot, the next PC is the lane PC plus the instruction size and the next-next PC is the target. All sums are taken modulo 2^AW.
- R5: Without a delay slot, taken is high when the lane's next PC differs from its PC plus the instruction size. With a delay slot, taken is high when the lane's next-next PC differs from its next PC plus the instruction size.
- R6: The unblock for the thread is raised with its squash when that thread's state code is 1 (blocked) or 2 (unblocking). State codes 0 (running) and 3 (squashing) give no unblock.
- R7: When several lanes mispredict, the lowest-indexed one is used.
- R8: The block request for the thread is raised with its squash exactly when some valid lane has a higher index than the redirect lane.
- R9: The fix outputs report, one cycle after a redirect, the lane index and the corrected predicted PC pair built by the R4 rule, with the predicted micro-PC zero. All fix outputs are zero otherwise.
- R10: The mispredict counter rises by one, modulo 2^CNTW, for each redirect and holds otherwise.
- R11: Asserting reset clears all messages, unblocks, block requests, fix outputs and the counter.
- R12: Lanes that are not valid, or whose branch-known bit is low, never cause a redirect, whatever their target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| grp_tid | input | TIDW | Thread that owns the current group |
| thr_state | input | THREADS x 2 | Decode state per thread (0 run, 1 blocked, 2 unblocking, 3 squashing) |
| ln_valid | input | LANES | Lane holds an instruction |
| ln_known | input | LANES | Lane is a branch with target resolved at decode |
| ln_seq | input | LANES x SEQW | Sequence number per lane |
| ln_pc | input | LANES x AW | Instruction PC per lane |
| ln_npc | input | LANES x AW | Next PC recorded per lane |
| ln_nnpc | input | LANES x AW | Next-next PC recorded per lane |
| ln_pred | input | LANES x AW | PC predicted by fetch per lane |
| ln_tgt | input | LANES x AW | Branch target resolved in decode per lane |
| ln_upc | input | LANES x UPCW | Micro-PC per lane |
| fx_mispredict | output | THREADS | Branch mispredict flag per thread |
| fx_pred_bad | output | THREADS | Prediction-incorrect flag per thread |
| fx_squash | output | THREADS | Squash flag per thread |
| fx_done_seq | output | THREADS x SEQW | Completed sequence number per thread |
| fx_next_upc | output | THREADS x UPCW | Next micro-PC per thread |
| fx_next_pc | output | THREADS x AW | Redirect next PC per thread |
| fx_next_npc | output | THREADS x AW | Redirect next-next PC per thread |
| fx_taken | output | THREADS | Branch-taken indication per thread |
| fx_unblock | output | THREADS | Unblock request to fetch per thread |
| blk_req | output | THREADS | Block request toward the skid buffer per thread |
| fix_valid | output | 1 | Corrected prediction present |
| fix_lane | output | LIW | Lane whose prediction is corrected |
| fix_pc | output | AW | Corrected predicted PC |
| fix_npc | output | AW | Corrected predicted next PC |
| fix_upc | output | UPCW | Corrected predicted micro-PC |
| mispred_cnt | output | CNTW | Count of detected mispredictions |

## Verification
The bench builds two copies side by side, one without and one with a delay slot. Both use two threads, three lanes, an 8-bit address, an 8-bit sequence number and an 8-bit counter. The narrow address makes the PC-plus-size wraps of R4 and R5 occur routinely as the generated PCs sweep the whole space. The 8-bit counter wraps several times during the sweep. Three lanes allow every combination of valid, branch-known and target-mismatch bits to be applied, for each of the four state codes and both thread ids, which covers the lane priority, the block request and the unblock cases.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_BLOCKED   = 2'd1,
    ST_UNBLOCKING = 2'd2,
    ST_SQUASHING = 2'd3
  } thr_state_e;
endpackage

// File: rtl/dr_lane_eval.sv
module dr_lane_eval #(
  parameter int AW         = 32,
  parameter int ISZ        = 4,
  parameter bit DELAY_SLOT = 1'b0
) (
  input  logic          valid,
  input  logic          known,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] npc,
  input  logic [AW-1:0] nnpc,
  input  logic [AW-1:0] pred,
  input  logic [AW-1:0] tgt,
  output logic          miss,
  output logic [AW-1:0] redir_pc,
  output logic [AW-1:0] redir_npc,
  output logic          taken
);
  localparam logic [AW-1:0] ISZ_W = AW'(ISZ);

  logic [AW-1:0] pc_step;
  logic [AW-1:0] npc_step;
  logic [AW-1:0] tgt_step;
  logic          taken_flat;
  logic          taken_slot;

  always_comb begin
    pc_step    = pc + ISZ_W;
    npc_step   = npc + ISZ_W;
    tgt_step   = tgt + ISZ_W;
    taken_flat = (npc != pc_step);
    taken_slot = (nnpc != npc_step);
    miss       = valid & known & (tgt != pred);
    redir_pc   = DELAY_SLOT ? pc_step : tgt;
    redir_npc  = DELAY_SLOT ? tgt : tgt_step;
    taken      = DELAY_SLOT ? taken_slot : taken_flat;
  end
endmodule

// File: rtl/dr_first_pick.sv
module dr_first_pick #(
  parameter int LANES = 4,
  localparam int LIW  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] miss,
  input  logic [LANES-1:0] valid,
  output logic             hit,
  output logic [LIW-1:0]   idx,
  output logic             rest
);
  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    rest = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (hit && valid[i]) rest = 1'b1;
      if (!hit && miss[i]) begin
        hit = 1'b1;
        idx = LIW'(i);
      end
    end
  end
endmodule

// File: rtl/dr_thread_msg.sv
module dr_thread_msg #(
  parameter int AW   = 32,
  parameter int SEQW = 16,
  parameter int UPCW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic            stalled,
  input  logic            more,
  input  logic [SEQW-1:0] seq,
  input  logic [UPCW-1:0] upc,
  input  logic [AW-1:0]   rpc,
  input  logic [AW-1:0]   rnpc,
  input  logic            taken,
  output logic            mispredict,
  output logic            pred_bad,
  output logic            squash,
  output logic [SEQW-1:0] done_seq,
  output logic [UPCW-1:0] next_upc,
  output logic [AW-1:0]   next_pc,
  output logic [AW-1:0]   next_npc,
  output logic            taken_o,
  output logic            unblock,
  output logic            blk
);
  logic            en;
  logic            mp_n, pb_n, sq_n, tk_n, ub_n, bk_n;
  logic [SEQW-1:0] seq_n;
  logic [UPCW-1:0] upc_n;
  logic [AW-1:0]   pc_n, npc_n;

  always_comb begin
    en    = fire | squash;
    mp_n  = fire;
    pb_n  = fire;
    sq_n  = fire;
    tk_n  = fire & taken;
    ub_n  = fire & stalled;
    bk_n  = fire & more;
    seq_n = fire ? seq  : '0;
    upc_n = fire ? upc  : '0;
    pc_n  = fire ? rpc  : '0;
    npc_n = fire ? rnpc : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mispredict <= 1'b0;
      pred_bad   <= 1'b0;
      squash     <= 1'b0;
      taken_o    <= 1'b0;
      unblock    <= 1'b0;
      blk        <= 1'b0;
      done_seq   <= '0;
      next_upc   <= '0;
      next_pc    <= '0;
      next_npc   <= '0;
    end else if (en) begin
      mispredict <= mp_n;
      pred_bad   <= pb_n;
      squash     <= sq_n;
      taken_o    <= tk_n;
      unblock    <= ub_n;
      blk        <= bk_n;
      done_seq   <= seq_n;
      next_upc   <= upc_n;
      next_pc    <= pc_n;
      next_npc   <= npc_n;
    end
  end

  AST_UNBLOCK_WITH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    unblock |-> squash); // R6
  AST_BLOCK_WITH_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> squash); // R8
  AST_FLAGS_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> (mispredict && pred_bad)); // R2
endmodule

// File: rtl/dec_redirect.sv
module dec_redirect #(
  parameter int AW         = 32,
  parameter int SEQW       = 16,
  parameter int UPCW       = 4,
  parameter int LANES      = 4,
  parameter int THREADS    = 2,
  parameter int ISZ        = 4,
  parameter int CNTW       = 16,
  parameter bit DELAY_SLOT = 1'b0,
  localparam int LIW       = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int TIDW      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TIDW-1:0]               grp_tid,
  input  logic [THREADS-1:0][1:0]       thr_state,
  input  logic [LANES-1:0]              ln_valid,
  input  logic [LANES-1:0]              ln_known,
  input  logic [LANES-1:0][SEQW-1:0]    ln_seq,
  input  logic [LANES-1:0][AW-1:0]      ln_pc,
  input  logic [LANES-1:0][AW-1:0]      ln_npc,
  input  logic [LANES-1:0][AW-1:0]      ln_nnpc,
  input  logic [LANES-1:0][AW-1:0]      ln_pred,
  input  logic [LANES-1:0][AW-1:0]      ln_tgt,
  input  logic [LANES-1:0][UPCW-1:0]    ln_upc,
  output logic [THREADS-1:0]            fx_mispredict,
  output logic [THREADS-1:0]            fx_pred_bad,
  output logic [THREADS-1:0]            fx_squash,
  output logic [THREADS-1:0][SEQW-1:0]  fx_done_seq,
  output logic [THREADS-1:0][UPCW-1:0]  fx_next_upc,
  output logic [THREADS-1:0][AW-1:0]    fx_next_pc,
  output logic [THREADS-1:0][AW-1:0]    fx_next_npc,
  output logic [THREADS-1:0]            fx_taken,
  output logic [THREADS-1:0]            fx_unblock,
  output logic [THREADS-1:0]            blk_req,
  output logic                          fix_valid,
  output logic [LIW-1:0]                fix_lane,
  output logic [AW-1:0]                 fix_pc,
  output logic [AW-1:0]                 fix_npc,
  output logic [UPCW-1:0]               fix_upc,
  output logic [CNTW-1:0]               mispred_cnt
);
  import dr_pkg::*;

  logic [LANES-1:0]         miss;
  logic [LANES-1:0][AW-1:0] rpc;
  logic [LANES-1:0][AW-1:0] rnpc;
  logic [LANES-1:0]         rtaken;
  logic                     hit;
  logic [LIW-1:0]           idx;
  logic                     rest;
  logic                     stalled;
  thr_state_e               cur_state;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dr_lane_eval #(.AW(AW), .ISZ(ISZ), .DELAY_SLOT(DELAY_SLOT)) u_eval (
      .valid     (ln_valid[l]),
      .known     (ln_known[l]),
      .pc        (ln_pc[l]),
      .npc       (ln_npc[l]),
      .nnpc      (ln_nnpc[l]),
      .pred      (ln_pred[l]),
      .tgt       (ln_tgt[l]),
      .miss      (miss[l]),
      .redir_pc  (rpc[l]),
      .redir_npc (rnpc[l]),
      .taken     (rtaken[l])
    );
  end

  dr_first_pick #(.LANES(LANES)) u_pick (
    .miss  (miss),
    .valid (ln_valid),
    .hit   (hit),
    .idx   (idx),
    .rest  (rest)
  );

  always_comb begin
    cur_state = thr_state_e'(thr_state[grp_tid]);
    stalled   = (cur_state == ST_BLOCKED) || (cur_state == ST_UNBLOCKING);
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic fire_t;
    assign fire_t = hit && (grp_tid == TIDW'(t));
    dr_thread_msg #(.AW(AW), .SEQW(SEQW), .UPCW(UPCW)) u_msg (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire_t),
      .stalled    (stalled),
      .more       (rest),
      .seq        (ln_seq[idx]),
      .upc        (ln_upc[idx]),
      .rpc        (rpc[idx]),
      .rnpc       (rnpc[idx]),
      .taken      (rtaken[idx]),
      .mispredict (fx_mispredict[t]),
      .pred_bad   (fx_pred_bad[t]),
      .squash     (fx_squash[t]),
      .done_seq   (fx_done_seq[t]),
      .next_upc   (fx_next_upc[t]),
      .next_pc    (fx_next_pc[t]),
      .next_npc   (fx_next_npc[t]),
      .taken_o    (fx_taken[t]),
      .unblock    (fx_unblock[t]),
      .blk        (blk_req[t])
    );
  end

  // corrected prediction fields for the offending instruction
  logic           fix_en;
  logic           fix_valid_n;
  logic [LIW-1:0] fix_lane_n;
  logic [AW-1:0]  fix_pc_n, fix_npc_n;

  always_comb begin
    fix_en      = hit | fix_valid;
    fix_valid_n = hit;
    fix_lane_n  = hit ? idx       : '0;
    fix_pc_n    = hit ? rpc[idx]  : '0;
    fix_npc_n   = hit ? rnpc[idx] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_valid <= 1'b0;
      fix_lane  <= '0;
      fix_pc    <= '0;
      fix_npc   <= '0;
    end else if (fix_en) begin
      fix_valid <= fix_valid_n;
      fix_lane  <= fix_lane_n;
      fix_pc    <= fix_pc_n;
      fix_npc   <= fix_npc_n;
    end
  end

  assign fix_upc = '0;

  // mispredict counter
  logic            cnt_en;
  logic [CNTW-1:0] cnt_n;

  always_comb begin
    cnt_en = hit;
    cnt_n  = mispred_cnt + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mispred_cnt <= '0;
    else if (cnt_en)  mispred_cnt <= cnt_n;
  end

  AST_ONE_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fx_squash)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (|fx_squash) |-> (mispred_cnt == $past(mispred_cnt) + CNTW'(1))); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(|fx_squash) |-> $stable(mispred_cnt)); // R10
  AST_FIX_TRACKS_SQUASH: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid == (|fx_squash)); // R9
  AST_NO_MISS_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (miss == '0) |=> (fx_squash == '0)); // R12
endmodule

// File: tb/sim_dec_redirect.sv
module sim_dec_redirect;
  localparam int CLK_P = 10;
  localparam int AW = 8, SEQW = 8, UPCW = 4, L = 3, T = 2, CW = 8, ISZ = 4;

  logic clk, rst_n;
  logic [0:0]          grp_tid;
  logic [T-1:0][1:0]   thr_state;
  logic [L-1:0]        ln_valid, ln_known;
  logic [L-1:0][SEQW-1:0] ln_seq;
  logic [L-1:0][AW-1:0]   ln_pc, ln_npc, ln_nnpc, ln_pred, ln_tgt;
  logic [L-1:0][UPCW-1:0] ln_upc;

  logic [1:0][T-1:0] mp, pb, sq, tk, ub, bk;
  logic [1:0][T-1:0][SEQW-1:0] dseq;
  logic [1:0][T-1:0][UPCW-1:0] nupc;
  logic [1:0][T-1:0][AW-1:0]   npc_o, nnpc_o;
  logic [1:0]           fv;
  logic [1:0][1:0]      fl;
  logic [1:0][AW-1:0]   fpc, fnpc;
  logic [1:0][UPCW-1:0] fupc;
  logic [1:0][CW-1:0]   cnt;

  int n_chk = 0;
  int n_fail = 0;
  logic [CW-1:0] exp_cnt;

  dec_redirect #(.AW(AW), .SEQW(SEQW), .UPCW(UPCW), .LANES(L), .THREADS(T),
                 .ISZ(ISZ), .CNTW(CW), .DELAY_SLOT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .grp_tid(grp_tid), .thr_state(thr_state),
    .ln_valid(ln_valid), .ln_known(ln_known), .ln_seq(ln_seq), .ln_pc(ln_pc),
    .ln_npc(ln_npc), .ln_nnpc(ln_nnpc), .ln_pred(ln_pred), .ln_tgt(ln_tgt),
    .ln_upc(ln_upc), .fx_mispredict(mp[0]), .fx_pred_bad(pb[0]),
    .fx_squash(sq[0]), .fx_done_seq(dseq[0]), .fx_next_upc(nupc[0]),
    .fx_next_pc(npc_o[0]), .fx_next_npc(nnpc_o[0]), .fx_taken(tk[0]),
    .fx_unblock(ub[0]), .blk_req(bk[0]), .fix_valid(fv[0]), .fix_lane(fl[0]),
    .fix_pc(fpc[0]), .fix_npc(fnpc[0]), .fix_upc(fupc[0]), .mispred_cnt(cnt[0]));

  dec_redirect #(.AW(AW), .SEQW(SEQW), .UPCW(UPCW), .LANES(L), .THREADS(T),
                 .ISZ(ISZ), .CNTW(CW), .DELAY_SLOT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .grp_tid(grp_tid), .thr_state(thr_state),
    .ln_valid(ln_valid), .ln_known(ln_known), .ln_seq(ln_seq), .ln_pc(ln_pc),
    .ln_npc(ln_npc), .ln_nnpc(ln_nnpc), .ln_pred(ln_pred), .ln_tgt(ln_tgt),
    .ln_upc(ln_upc), .fx_mispredict(mp[1]), .fx_pred_bad(pb[1]),
    .fx_squash(sq[1]), .fx_done_seq(dseq[1]), .fx_next_upc(nupc[1]),
    .fx_next_pc(npc_o[1]), .fx_next_npc(nnpc_o[1]), .fx_taken(tk[1]),
    .fx_unblock(ub[1]), .blk_req(bk[1]), .fix_valid(fv[1]), .fix_lane(fl[1]),
    .fix_pc(fpc[1]), .fix_npc(fnpc[1]), .fix_upc(fupc[1]), .mispred_cnt(cnt[1]));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    for (int d = 0; d < 2; d++) begin
      chk(req, 32'(sq[d]), 0);
      chk(req, 32'(mp[d]), 0);
      chk(req, 32'(ub[d]), 0);
      chk(req, 32'(bk[d]), 0);
      chk(req, 32'(fv[d]), 0);
      chk(req, 32'(cnt[d]), 0);
    end
  endtask

  initial begin
    #(CLK_P*150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R11 actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g;
    rst_n = 1'b0;
    grp_tid = '0; thr_state = '0; ln_valid = '0; ln_known = '0;
    ln_seq = '0; ln_pc = '0; ln_npc = '0; ln_nnpc = '0; ln_pred = '0;
    ln_tgt = '0; ln_upc = '0;
    exp_cnt = '0;
    repeat (3) @(negedge clk);
    check_idle("R11 reset");
    rst_n = 1'b1;
    g = 0;
    for (int st = 0; st < 4; st++)
    for (int tid = 0; tid < 2; tid++)
    for (int v = 0; v < 8; v++)
    for (int k = 0; k < 8; k++)
    for (int mm = 0; mm < 8; mm++) begin
      logic hit, rest;
      int f;
      // drive the group
      grp_tid = 1'(tid);
      thr_state[tid] = 2'(st);
      thr_state[1-tid] = 2'(3 - st);
      ln_valid = 3'(v);
      ln_known = 3'(k);
      for (int i = 0; i < L; i++) begin
        ln_pc[i]   = 8'(g*12 + i*4);
        ln_npc[i]  = (((g + i) & 1) != 0) ? 8'(ln_pc[i] + 4) : 8'(ln_pc[i] + 8);
        ln_nnpc[i] = ((((g >> 1) + i) & 1) != 0) ? 8'(ln_npc[i] + 4) : 8'(ln_npc[i] + 16);
        ln_pred[i] = 8'(ln_pc[i] + 8'h30 + i);
        ln_tgt[i]  = mm[i] ? 8'(ln_pred[i] + 8'h20) : ln_pred[i];
        ln_seq[i]  = 8'(g*3 + i);
        ln_upc[i]  = 4'(g + i*5);
      end
      // expected values from the requirements
      hit = 1'b0; f = 0; rest = 1'b0;
      for (int i = 0; i < L; i++) begin
        if (hit && v[i]) rest = 1'b1;             // R8
        if (!hit && v[i] && k[i] && mm[i]) begin  // R1 R12 R7
          hit = 1'b1; f = i;
        end
      end
      if (hit) exp_cnt = exp_cnt + 8'd1;
      @(negedge clk);
      for (int d = 0; d < 2; d++) begin
        logic [7:0] epc, enpc;
        logic etk, estall;
        epc  = (d == 1) ? 8'(ln_pc[f] + 4) : ln_tgt[f];
        enpc = (d == 1) ? ln_tgt[f] : 8'(ln_tgt[f] + 4);
        etk  = (d == 1) ? (ln_nnpc[f] != 8'(ln_npc[f] + 4))
                        : (ln_npc[f] != 8'(ln_pc[f] + 4));
        estall = (st == 1) || (st == 2);
        for (int t = 0; t < T; t++) begin
          logic on;
          on = hit && (tid == t);
          chk("R1 R12 squash", 32'(sq[d][t]), 32'(on));
          chk("R2 mispredict flag", 32'(mp[d][t]), 32'(on));
          chk("R2 pred-bad flag", 32'(pb[d][t]), 32'(on));
          chk("R3 done seq", 32'(dseq[d][t]), on ? 32'(ln_seq[f]) : 0);
          chk("R3 next upc", 32'(nupc[d][t]), on ? 32'(ln_upc[f]) : 0);
          chk("R4 next pc", 32'(npc_o[d][t]), on ? 32'(epc) : 0);
          chk("R4 next npc", 32'(nnpc_o[d][t]), on ? 32'(enpc) : 0);
          chk("R5 taken", 32'(tk[d][t]), 32'(on && etk));
          chk("R6 unblock", 32'(ub[d][t]), 32'(on && estall));
          chk("R8 block request", 32'(bk[d][t]), 32'(on && rest));
        end
        chk("R9 fix valid", 32'(fv[d]), 32'(hit));
        chk("R7 R9 fix lane", 32'(fl[d]), hit ? 32'(f) : 0);
        chk("R9 fix pc", 32'(fpc[d]), hit ? 32'(epc) : 0);
        chk("R9 fix npc", 32'(fnpc[d]), hit ? 32'(enpc) : 0);
        chk("R9 fix upc", 32'(fupc[d]), 0);
        chk("R10 counter", 32'(cnt[d]), 32'(exp_cnt));
      end
      g++;
    end
    // a quiet group: pulse ends, counter holds
    ln_valid = '0;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R2 pulse ends", 32'(sq[d]), 0);
      chk("R10 counter hold", 32'(cnt[d]), 32'(exp_cnt));
    end
    // reset again mid-run with a mispredicting group applied
    ln_valid = 3'b111; ln_known = 3'b111;
    ln_tgt[0] = 8'(ln_pred[0] + 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R11 reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule